// File: doc/BRIEF.md
# Typed-Pin Boundary Scan Register

This block sits between the core logic and the I/O pads. It forms one serial test data register out of cells whose number depends on the pin's type. An input-only pin or an output-only pin adds one bit to the chain. A tri-state output adds two bits. A bidirectional pin adds three bits. A test controller selects the register with the all-zeros value of a 4-bit instruction. It then drives capture, shift and update strobes, synchronous to the test clock, and moves data in on `tdi_i` and out on `tdo_o`.

While no update has been applied, the block is transparent. Core output values and enables go to the pads, and pad input values go to the core. After an update while the register is selected, the values held in the update stage replace the core-side inputs and the pad outputs and enables. This continues until a test-logic reset or the asynchronous reset returns the pins to pass-through. The scan path runs on the test clock only, so it works the same whether the core is held in reset or running.

Top module: `bsr_chain`

## Requirements
- R1: The register is selected only when `ir_i` is 4'b0000. With any other code, capture, shift and update strobes have no effect: `tdo_o`, the chain contents and all pin outputs are left unchanged.
- R2: Pin kinds add 1 (input), 1 (output), 2 (tri-state) or 3 (bidirectional) bits. The default chain of input, output, tri-state, bidirectional, bidirectional is therefore 10 bits long.
- R3: Chain position 0 is the first bit of pin 0, and `tdo_o` shows it. Pins follow in index order. A tri-state pin holds output value then enable. A bidirectional pin holds input, output value, then enable. The first bit shifted in ends up at position 0 after a full-length shift.
- R4: On a selected capture strobe, each input bit loads `pad_i_i`, each output-value bit loads `core_o_i`, and each enable bit loads `core_oe_i` of its pin.
- R5: Each selected shift strobe moves every bit one position toward `tdo_o`, and `tdi_i` enters the last position.
- R6: Pin outputs do not change while bits are being shifted. They change only on an update strobe.
- R7: After a selected update, `core_i_o`, `pad_o_o` and `pad_oe_o` take the updated bit values of the pins that have those bits.
- R8: In pass-through, `core_i_o` equals `pad_i_i` for input and bidirectional pins, and is 0 for the other kinds. `pad_o_o` equals `core_o_i` for output-capable pins, and is 0 for input pins. `pad_oe_o` equals `core_oe_i` for tri-state and bidirectional pins, is 1 for output pins and is 0 for input pins.
- R9: A `tap_reset_i` strobe, or `rst_ni` going low, returns all pins to pass-through. `rst_ni` low also clears the chain, so `tdo_o` reads 0.
- R10: Capture takes priority over shift in the same cycle, and `tap_reset_i` takes priority over update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | IR_W | Current instruction; all zeros selects this register |
| tap_reset_i | input | 1 | Test-logic reset strobe; leaves override mode |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, from chain position 0 |
| pad_i_i | input | NUM_PINS | Pad-side input value per pin |
| core_o_i | input | NUM_PINS | Core-side output value per pin |
| core_oe_i | input | NUM_PINS | Core-side output enable per pin |
| core_i_o | output | NUM_PINS | Value presented to the core per pin |
| pad_o_o | output | NUM_PINS | Value driven toward the pad per pin |
| pad_oe_o | output | NUM_PINS | Enable driven toward the pad per pin |

## Verification
The hardest situation to reach from the ports is one where the pin outputs have to stay frozen while new data streams through the chain. This needs override mode already active and the shift stage holding different data. The stimulus gets there by running all 1024 chain patterns back to back. Each shift starts from the previous pattern's update, and the outputs are compared on every shift cycle. The capture-versus-shift and reset-versus-update collisions are driven as same-cycle strobe pairs, and the outcome is read back through a full shift-out or at the pins.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    KIND_IN    = 2'd0,
    KIND_OUT   = 2'd1,
    KIND_TRI   = 2'd2,
    KIND_BIDIR = 2'd3
  } pin_kind_e;

  function automatic int kind_bits(logic [1:0] k);
    case (k)
      KIND_IN, KIND_OUT: return 1;
      KIND_TRI:          return 2;
      default:           return 3;
    endcase
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic upd_en_i,
  input  logic cap_d_i,
  input  logic scan_i,
  output logic scan_o,
  output logic upd_o
);
  logic shift_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shift_q <= 1'b0;
    else if (cap_en_i)   shift_q <= cap_d_i;
    else if (shift_en_i) shift_q <= scan_i;
  end

  // separate update stage keeps pins still during shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (upd_en_i) upd_q <= shift_q;
  end

  assign scan_o = shift_q;
  assign upd_o  = upd_q;

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> scan_o == $past(cap_d_i));
  p_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !cap_en_i) |=> scan_o == $past(scan_i));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(upd_o));
endmodule

// File: rtl/bsr_pin.sv
module bsr_pin
  import bsr_pkg::*;
#(
  parameter logic [1:0] KIND = 2'd0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic upd_en_i,
  input  logic override_i,
  input  logic scan_i,
  output logic scan_o,
  input  logic pad_i_i,
  input  logic core_o_i,
  input  logic core_oe_i,
  output logic core_i_o,
  output logic pad_o_o,
  output logic pad_oe_o
);
  localparam int NB = kind_bits(KIND);

  logic [NB-1:0] cap_d, upd;
  logic [NB:0]   link;

  assign link[NB] = scan_i;
  assign scan_o   = link[0];

  for (genvar b = 0; b < NB; b++) begin : g_bit
    bsr_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (cap_en_i),
      .shift_en_i (shift_en_i),
      .upd_en_i   (upd_en_i),
      .cap_d_i    (cap_d[b]),
      .scan_i     (link[b+1]),
      .scan_o     (link[b]),
      .upd_o      (upd[b])
    );
  end

  if (KIND == KIND_IN) begin : g_in
    logic unused_in;
    assign unused_in = core_o_i ^ core_oe_i;
    assign cap_d    = pad_i_i;
    assign core_i_o = override_i ? upd[0] : pad_i_i;
    assign pad_o_o  = 1'b0;
    assign pad_oe_o = 1'b0;
  end else if (KIND == KIND_OUT) begin : g_out
    logic unused_out;
    assign unused_out = pad_i_i ^ core_oe_i;
    assign cap_d    = core_o_i;
    assign core_i_o = 1'b0;
    assign pad_o_o  = override_i ? upd[0] : core_o_i;
    assign pad_oe_o = 1'b1;
  end else if (KIND == KIND_TRI) begin : g_tri
    logic unused_tri;
    assign unused_tri = pad_i_i;
    assign cap_d    = {core_oe_i, core_o_i};
    assign core_i_o = 1'b0;
    assign pad_o_o  = override_i ? upd[0] : core_o_i;
    assign pad_oe_o = override_i ? upd[1] : core_oe_i;
  end else begin : g_bidir
    assign cap_d    = {core_oe_i, core_o_i, pad_i_i};
    assign core_i_o = override_i ? upd[0] : pad_i_i;
    assign pad_o_o  = override_i ? upd[1] : core_o_i;
    assign pad_oe_o = override_i ? upd[2] : core_oe_i;
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int                    NUM_PINS  = 5,
  parameter int                    IR_W      = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 10'b11_11_10_01_00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IR_W-1:0]     ir_i,
  input  logic                tap_reset_i,
  input  logic                capture_i,
  input  logic                shift_i,
  input  logic                update_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic [NUM_PINS-1:0] pad_i_i,
  input  logic [NUM_PINS-1:0] core_o_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [NUM_PINS-1:0] core_i_o,
  output logic [NUM_PINS-1:0] pad_o_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic sel, cap_en, shift_en, upd_en, override_q;
  logic [NUM_PINS:0] chain;

  assign sel      = (ir_i == '0);
  assign cap_en   = sel & capture_i;
  assign shift_en = sel & shift_i;
  assign upd_en   = sel & update_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          override_q <= 1'b0;
    else if (tap_reset_i) override_q <= 1'b0;
    else if (upd_en)      override_q <= 1'b1;
  end

  assign chain[NUM_PINS] = tdi_i;
  assign tdo_o           = chain[0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    bsr_pin #(.KIND(PIN_KINDS[2*p +: 2])) u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (cap_en),
      .shift_en_i (shift_en),
      .upd_en_i   (upd_en),
      .override_i (override_q),
      .scan_i     (chain[p+1]),
      .scan_o     (chain[p]),
      .pad_i_i    (pad_i_i[p]),
      .core_o_i   (core_o_i[p]),
      .core_oe_i  (core_oe_i[p]),
      .core_i_o   (core_i_o[p]),
      .pad_o_o    (pad_o_o[p]),
      .pad_oe_o   (pad_oe_o[p])
    );
  end

  p_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> $stable(tdo_o));
  p_enter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && !tap_reset_i) |=> override_q);
  p_tap_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_reset_i |=> !override_q);
  p_reset_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_reset_i && update_i) |=> !override_q);
endmodule

// File: tb/bsr_chain_bench.sv
`timescale 1ns/1ps
module bsr_chain_bench;
  localparam int NP = 5;
  localparam int L  = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] ir = 4'd0;
  logic tap_reset = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NP-1:0] pad_i = '0, core_o = '0, core_oe = '0;
  logic [NP-1:0] core_i, pad_o, pad_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int kinds [NP] = '{0, 1, 2, 3, 3};

  always #10 clk = ~clk;

  bsr_chain u_bsr_chain (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir), .tap_reset_i(tap_reset),
    .capture_i(capture), .shift_i(shift), .update_i(update), .tdi_i(tdi),
    .tdo_o(tdo), .pad_i_i(pad_i), .core_o_i(core_o), .core_oe_i(core_oe),
    .core_i_o(core_i), .pad_o_o(pad_o), .pad_oe_o(pad_oe)
  );

  wire [3*NP-1:0] outs = {core_i, pad_o, pad_oe};

  function automatic logic [3*NP-1:0] exp_out(bit m, logic [L-1:0] v,
      logic [NP-1:0] pi, logic [NP-1:0] co, logic [NP-1:0] coe);
    logic [NP-1:0] ci, po, poe;
    int off = 0;
    for (int p = 0; p < NP; p++) begin
      ci[p] = 1'b0; po[p] = 1'b0; poe[p] = 1'b0;
      case (kinds[p])
        0: begin ci[p] = m ? v[off] : pi[p]; off += 1; end
        1: begin po[p] = m ? v[off] : co[p]; poe[p] = 1'b1; off += 1; end
        2: begin po[p] = m ? v[off] : co[p]; poe[p] = m ? v[off+1] : coe[p]; off += 2; end
        default: begin
          ci[p] = m ? v[off] : pi[p]; po[p] = m ? v[off+1] : co[p];
          poe[p] = m ? v[off+2] : coe[p]; off += 3;
        end
      endcase
    end
    return {ci, po, poe};
  endfunction

  function automatic logic [L-1:0] cap_vec(logic [NP-1:0] pi,
      logic [NP-1:0] co, logic [NP-1:0] coe);
    logic [L-1:0] v = '0;
    int off = 0;
    for (int p = 0; p < NP; p++) begin
      case (kinds[p])
        0: begin v[off] = pi[p]; off += 1; end
        1: begin v[off] = co[p]; off += 1; end
        2: begin v[off] = co[p]; v[off+1] = coe[p]; off += 2; end
        default: begin v[off] = pi[p]; v[off+1] = co[p]; v[off+2] = coe[p]; off += 3; end
      endcase
    end
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit c, input bit s, input bit u, input bit r);
    capture = c; shift = s; update = u; tap_reset = r;
    @(negedge clk);
    capture = 0; shift = 0; update = 0; tap_reset = 0;
  endtask

  task automatic do_shift(input logic [L-1:0] din, output logic [L-1:0] dout,
                          input bit hold_chk);
    logic [3*NP-1:0] snap;
    snap = outs;
    for (int i = 0; i < L; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shift = 1'b1;
      @(negedge clk);
      if (hold_chk) chk("R6", outs, snap);
    end
    shift = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [L-1:0] dout, prev, v;
    logic [14:0] n;
    #25;
    chk("R9", tdo, 0);
    chk("R8", outs, exp_out(0, '0, pad_i, core_o, core_oe));
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8: pass-through over every input combination
    for (int k = 0; k < 32768; k++) begin
      n = k[14:0];
      {pad_i, core_o, core_oe} = n;
      #1;
      chk("R8", outs, exp_out(0, '0, pad_i, core_o, core_oe));
    end
    @(negedge clk);

    // R4: capture sweep
    for (int k = 0; k < 256; k++) begin
      n = 15'((k * 1237 + 11) % 32768);
      {pad_i, core_o, core_oe} = n;
      pulse(1, 0, 0, 0);
      do_shift('0, dout, 0);
      chk("R4", dout, cap_vec(pad_i, core_o, core_oe));
    end

    // R3 R5 R6 R7: every chain pattern, back to back
    {pad_i, core_o, core_oe} = 15'h2B5C;
    prev = '0;
    for (int k = 0; k < 1024; k++) begin
      v = k[L-1:0];
      do_shift(v, dout, k > 0);
      chk("R5", dout, prev);
      pulse(0, 0, 1, 0);
      chk("R7", outs, exp_out(1, v, pad_i, core_o, core_oe));
      prev = v;
    end

    // R2: first bit in reaches tdo after exactly L shifts
    do_shift(10'h001, dout, 0);
    chk("R2", tdo, 1);
    // R3: only the tri-state enable bit (position 3) set
    do_shift(10'h008, dout, 0);
    pulse(0, 0, 1, 0);
    chk("R3", pad_oe, 5'b00110);
    chk("R3", pad_o, 5'b00000);

    // R1: non-selecting codes ignore all strobes
    prev = 10'h008;
    for (int c = 1; c < 16; c++) begin
      ir = c[3:0];
      do_shift(10'h3FF, dout, 1);
      pulse(1, 0, 1, 0);
      chk("R1", tdo, 0);
      chk("R1", outs, exp_out(1, prev, pad_i, core_o, core_oe));
    end
    ir = 4'd0;
    do_shift('0, dout, 0);
    chk("R1", dout, prev);

    // R10: capture wins over shift
    {pad_i, core_o, core_oe} = 15'h5A3C;
    pulse(1, 1, 0, 0);
    do_shift('0, dout, 0);
    chk("R10", dout, cap_vec(pad_i, core_o, core_oe));

    // R9: tap reset returns to pass-through
    do_shift(10'h2AA, dout, 0);
    pulse(0, 0, 1, 0);
    chk("R7", outs, exp_out(1, 10'h2AA, pad_i, core_o, core_oe));
    pulse(0, 0, 0, 1);
    chk("R9", outs, exp_out(0, '0, pad_i, core_o, core_oe));

    // R10: tap reset wins over update
    pulse(0, 0, 1, 1);
    chk("R10", outs, exp_out(0, '0, pad_i, core_o, core_oe));

    // R9: asynchronous reset mid-override
    do_shift(10'h3FF, dout, 0);
    pulse(0, 0, 1, 0);
    chk("R7", outs, exp_out(1, 10'h3FF, pad_i, core_o, core_oe));
    #3 rst_ni = 1'b0;
    #1;
    chk("R9", outs, exp_out(0, '0, pad_i, core_o, core_oe));
    chk("R9", tdo, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule